// File: doc/BRIEF.md
# Transmit Gain Control Register Bank

This block sits behind a serial host port and turns byte-wide register writes into the gain-control settings of a transmit variable-gain chain. It sets three things: the 12-bit code for the analog attenuator's control DAC, the field that picks what drives that attenuator (the internal DAC or an external control pin), and the 5-bit code of the step attenuator.

The 12-bit attenuator code is split across two byte registers. A write to the high-nibble register (0x104) loads only a shadow nibble. A later write to the low-byte register (0x103) moves the shadow nibble and the new low byte into the active code on the same clock edge. The output therefore never holds a mix of old and new halves. The host writes 0x104 first and then 0x103.

Two step-attenuator registers are kept: 0x102 for the idle state and 0x112 for the transmit state. The transmit-enable input selects which one drives the output. Each LSB of the step code is 0.45 dB, and code 31 gives about 13.95 dB, so every 5-bit code is legal. A separate read address returns the stored register contents.

Top module: `tx_gain_regs`

## Requirements
- R1: After reset, atten_code_o, src_ext_o and step_code_o are 0, and reading 0x102, 0x103, 0x104, 0x105 and 0x112 returns 0x00.
- R2: A write to 0x104 stores wdata_i[3:0] in a shadow nibble and leaves atten_code_o unchanged. Reading 0x104 returns {4'b0, shadow}.
- R3: A write to 0x103 sets atten_code_o to {shadow nibble, wdata_i[7:0]} at the same clock edge that takes the write.
- R4: A write to 0x103 with no 0x104 write since the last transfer reuses the shadow nibble that is already held.
- R5: 0x105 stores wdata_i[1:0], and reading it returns {6'b0, stored}. src_ext_o is 1 only when the stored value is 2'b10. The values 00, 01 and 11 give 0, which selects the internal DAC.
- R6: step_code_o equals 0x102[4:0] while tx_en_i is 0 and 0x112[4:0] while tx_en_i is 1. The output follows tx_en_i combinationally.
- R7: 0x102 and 0x112 store wdata_i[4:0] and read back as {3'b0, stored}. All 32 codes reach step_code_o unchanged.
- R8: A write to any other address changes no output and no readable register. Reading an unmapped address returns 0x00.
- R9: atten_code_o changes only on the clock edge after a write to 0x103.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 12 | Write address |
| wdata_i | input | 8 | Write data |
| raddr_i | input | 12 | Read address |
| rdata_o | output | 8 | Read data (combinational) |
| tx_en_i | input | 1 | Transmit enable: selects the step-attenuator register |
| atten_code_o | output | 12 | Active analog-attenuator DAC code |
| src_ext_o | output | 1 | 1 = external pin drives the attenuator, 0 = internal DAC |
| step_code_o | output | 5 | Active step-attenuator code |

## Verification
The bench writes 0x104 and checks that atten_code_o stays the same until 0x103 is written. A design without the shadow register would let the high nibble show early. The bench also writes 0x103 twice with no 0x104 write in between, which catches a design that clears the shadow after each transfer. For the source field it sends the reserved values 01 and 11 and reads them back. A design that decodes only bit 1 would wrongly pick the external pin for 11, and one that masks the stored value would read back wrong. The bench toggles tx_en_i with different codes in the two step registers, and it writes to unmapped neighbour addresses (0x106, 0x113, 0x003). A decode that ignores upper address bits would then corrupt live settings.

// File: rtl/gain_regs_pkg.sv
package gain_regs_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int HI_W   = 4;
  localparam int ATT_W  = HI_W + DATA_W;
  localparam int STEP_W = 5;
  localparam int SRC_W  = 2;

  localparam logic [ADDR_W-1:0] A_STEP_IDLE = 12'h102;
  localparam logic [ADDR_W-1:0] A_ATT_LO    = 12'h103;
  localparam logic [ADDR_W-1:0] A_ATT_HI    = 12'h104;
  localparam logic [ADDR_W-1:0] A_SRC       = 12'h105;
  localparam logic [ADDR_W-1:0] A_STEP_TX   = 12'h112;

  localparam logic [SRC_W-1:0] SRC_EXT_CODE = 2'b10;
endpackage

// File: rtl/gain_atten_dbuf.sv
module gain_atten_dbuf #(
  parameter int HI_W = 4,
  parameter int LO_W = 8,
  localparam int OUT_W = HI_W + LO_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hi_we_i,
  input  logic             lo_we_i,
  input  logic [LO_W-1:0]  wdata_i,
  output logic [HI_W-1:0]  shadow_o,
  output logic [LO_W-1:0]  lo_o,
  output logic [OUT_W-1:0] code_o
);
  logic [HI_W-1:0] shadow_q;
  logic [LO_W-1:0] lo_q;
  logic [OUT_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      lo_q     <= '0;
      code_q   <= '0;
    end else begin
      if (hi_we_i) shadow_q <= wdata_i[HI_W-1:0];
      // low write commits shadow + new byte atomically
      if (lo_we_i) begin
        lo_q   <= wdata_i;
        code_q <= {shadow_q, wdata_i};
      end
    end
  end

  assign shadow_o = shadow_q;
  assign lo_o     = lo_q;
  assign code_o   = code_q;
endmodule

// File: rtl/gain_step_bank.sv
module gain_step_bank #(
  parameter int STEP_W = 5,
  parameter int N_BANK = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_BANK-1:0] we_i,
  input  logic [STEP_W-1:0] wdata_i,
  input  logic              tx_en_i,
  output logic [STEP_W-1:0] bank_o [N_BANK],
  output logic [STEP_W-1:0] step_o
);
  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    logic [STEP_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q <= '0;
      else if (we_i[g]) q <= wdata_i;
    end
    assign bank_o[g] = q;
  end

  // bank 0 = idle, bank 1 = transmit
  assign step_o = tx_en_i ? bank_o[1] : bank_o[0];
endmodule

// File: rtl/gain_src_sel.sv
module gain_src_sel #(
  parameter int               SRC_W   = 2,
  parameter logic [SRC_W-1:0] EXT_VAL = 2'b10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SRC_W-1:0] wdata_i,
  output logic [SRC_W-1:0] raw_o,
  output logic             ext_o
);
  logic [SRC_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wdata_i;
  end

  assign raw_o = q;
  // reserved codes fall back to internal DAC
  assign ext_o = (q == EXT_VAL);
endmodule

// File: rtl/tx_gain_regs.sv
module tx_gain_regs
  import gain_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tx_en_i,
  output logic [ATT_W-1:0]  atten_code_o,
  output logic              src_ext_o,
  output logic [STEP_W-1:0] step_code_o
);
  localparam int N_BANK = 2;

  logic              we_hi, we_lo, we_src;
  logic [N_BANK-1:0] we_step;
  logic [HI_W-1:0]   shadow;
  logic [DATA_W-1:0] lo_byte;
  logic [SRC_W-1:0]  src_raw;
  logic [STEP_W-1:0] step_bank [N_BANK];

  assign we_hi      = wr_en_i && (addr_i == A_ATT_HI);
  assign we_lo      = wr_en_i && (addr_i == A_ATT_LO);
  assign we_src     = wr_en_i && (addr_i == A_SRC);
  assign we_step[0] = wr_en_i && (addr_i == A_STEP_IDLE);
  assign we_step[1] = wr_en_i && (addr_i == A_STEP_TX);

  gain_atten_dbuf #(.HI_W(HI_W), .LO_W(DATA_W)) u_atten (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hi_we_i  (we_hi),
    .lo_we_i  (we_lo),
    .wdata_i  (wdata_i),
    .shadow_o (shadow),
    .lo_o     (lo_byte),
    .code_o   (atten_code_o)
  );

  gain_step_bank #(.STEP_W(STEP_W), .N_BANK(N_BANK)) u_step (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_step),
    .wdata_i (wdata_i[STEP_W-1:0]),
    .tx_en_i (tx_en_i),
    .bank_o  (step_bank),
    .step_o  (step_code_o)
  );

  gain_src_sel #(.SRC_W(SRC_W), .EXT_VAL(SRC_EXT_CODE)) u_src (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_src),
    .wdata_i (wdata_i[SRC_W-1:0]),
    .raw_o   (src_raw),
    .ext_o   (src_ext_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (raddr_i)
      A_STEP_IDLE: rdata_o[STEP_W-1:0] = step_bank[0];
      A_ATT_LO:    rdata_o             = lo_byte;
      A_ATT_HI:    rdata_o[HI_W-1:0]   = shadow;
      A_SRC:       rdata_o[SRC_W-1:0]  = src_raw;
      A_STEP_TX:   rdata_o[STEP_W-1:0] = step_bank[1];
      default:     rdata_o             = '0;
    endcase
  end
endmodule

// File: rtl/tx_gain_regs_chk.sv
module tx_gain_regs_chk
  import gain_regs_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              tx_en_i,
  input logic [ATT_W-1:0]  atten_code_o,
  input logic              src_ext_o,
  input logic [STEP_W-1:0] step_code_o
);
  logic mapped;
  assign mapped = (addr_i == A_STEP_IDLE) || (addr_i == A_ATT_LO) || (addr_i == A_ATT_HI) ||
                  (addr_i == A_SRC) || (addr_i == A_STEP_TX);

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_OUTPUTS_ZERO: assert (atten_code_o == '0 && !src_ext_o && step_code_o == '0); // R1
    end
  end

  AST_ATTEN_ONLY_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(atten_code_o) |-> $past(wr_en_i && addr_i == A_ATT_LO)); // R9

  AST_ATTEN_LOW_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_ATT_LO) |=> atten_code_o[DATA_W-1:0] == $past(wdata_i)); // R3

  AST_SRC_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(src_ext_o) |-> $past(wr_en_i && addr_i == A_SRC)); // R5

  AST_UNMAPPED_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !mapped) |=> ($stable(atten_code_o) && $stable(src_ext_o))); // R8

  AST_STEP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(step_code_o) |->
      (!$stable(tx_en_i) || $past(wr_en_i && (addr_i == A_STEP_IDLE || addr_i == A_STEP_TX)))); // R6
endmodule

bind tx_gain_regs tx_gain_regs_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .tx_en_i      (tx_en_i),
  .atten_code_o (atten_code_o),
  .src_ext_o    (src_ext_o),
  .step_code_o  (step_code_o)
);

// File: tb/tx_gain_regs_bench.sv
module tx_gain_regs_bench;
  import gain_regs_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [ADDR_W-1:0] raddr_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              tx_en_i = 1'b0;
  logic [ATT_W-1:0]  atten_code_o;
  logic              src_ext_o;
  logic [STEP_W-1:0] step_code_o;

  int checks = 0;
  int failures = 0;

  typedef struct {
    bit          is_read;
    string       tag;
    logic [11:0] exp_atten;
    logic        exp_ext;
    logic [4:0]  exp_step;
    logic [7:0]  exp_rdata;
  } item_t;

  item_t sb_q[$];

  // reference model from the requirements
  logic [3:0] m_shadow = '0;
  logic [7:0] m_lo = '0;
  logic [11:0] m_atten = '0;
  logic [1:0] m_src = '0;
  logic [4:0] m_idle = '0;
  logic [4:0] m_tx = '0;
  logic m_txen = 1'b0;

  tx_gain_regs u_tx_gain_regs (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [7:0] model_read(logic [11:0] a);
    case (a)
      12'h102: return {3'b0, m_idle};
      12'h103: return m_lo;
      12'h104: return {4'b0, m_shadow};
      12'h105: return {6'b0, m_src};
      12'h112: return {3'b0, m_tx};
      default: return 8'h00;
    endcase
  endfunction

  task automatic push_out(string tag);
    item_t it;
    it.is_read = 1'b0; it.tag = tag;
    it.exp_atten = m_atten;
    it.exp_ext = (m_src == 2'b10);
    it.exp_step = m_txen ? m_tx : m_idle;
    it.exp_rdata = '0;
    sb_q.push_back(it);
  endtask

  task automatic do_write(logic [11:0] a, logic [7:0] d, string tag);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    case (a)
      12'h102: m_idle = d[4:0];
      12'h103: begin m_lo = d; m_atten = {m_shadow, d}; end
      12'h104: m_shadow = d[3:0];
      12'h105: m_src = d[1:0];
      12'h112: m_tx = d[4:0];
      default: ;
    endcase
    @(negedge clk_i);
    wr_en_i = 1'b0;
    push_out(tag);
  endtask

  task automatic do_read(logic [11:0] a, string tag);
    item_t it;
    @(negedge clk_i);
    raddr_i = a;
    it.is_read = 1'b1; it.tag = tag;
    it.exp_atten = '0; it.exp_ext = 1'b0; it.exp_step = '0;
    it.exp_rdata = model_read(a);
    sb_q.push_back(it);
  endtask

  task automatic set_tx(logic v, string tag);
    @(negedge clk_i);
    tx_en_i = v; m_txen = v;
    push_out(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (it.is_read) begin
          if (rdata_o !== it.exp_rdata) begin
            failures++;
            $display("FAIL %s rdata act=%h exp=%h", it.tag, rdata_o, it.exp_rdata);
          end
        end else if (atten_code_o !== it.exp_atten || src_ext_o !== it.exp_ext ||
                     step_code_o !== it.exp_step) begin
          failures++;
          $display("FAIL %s outputs act=%h/%b/%h exp=%h/%b/%h", it.tag,
                   atten_code_o, src_ext_o, step_code_o,
                   it.exp_atten, it.exp_ext, it.exp_step);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*100000);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    push_out("R1");
    do_read(12'h102, "R1"); do_read(12'h103, "R1"); do_read(12'h104, "R1");
    do_read(12'h105, "R1"); do_read(12'h112, "R1");
    // R2 shadow only
    do_write(12'h104, 8'hA5, "R2");
    do_read(12'h104, "R2");
    // R3 atomic transfer
    do_write(12'h103, 8'h3C, "R3");
    do_read(12'h103, "R3");
    // R4 shadow reused
    do_write(12'h103, 8'hFF, "R4");
    do_write(12'h104, 8'h01, "R2");
    do_write(12'h103, 8'h00, "R3");
    do_write(12'h104, 8'h0F, "R9");
    set_tx(1'b0, "R9");
    // R5 source select
    do_write(12'h105, 8'h02, "R5"); do_read(12'h105, "R5");
    do_write(12'h105, 8'hFF, "R5"); do_read(12'h105, "R5");
    do_write(12'h105, 8'h01, "R5"); do_read(12'h105, "R5");
    do_write(12'h105, 8'h02, "R5");
    // R6 / R7 step banks
    do_write(12'h102, 8'hFF, "R7"); do_read(12'h102, "R7");
    do_write(12'h112, 8'h0A, "R6"); do_read(12'h112, "R7");
    set_tx(1'b1, "R6");
    set_tx(1'b0, "R6");
    set_tx(1'b1, "R6");
    do_write(12'h112, 8'hF3, "R7");
    for (int c = 0; c < 32; c += 7) do_write(12'h102, 8'(c), "R7");
    set_tx(1'b0, "R6");
    // R8 unmapped writes
    do_write(12'h106, 8'hFF, "R8");
    do_write(12'h113, 8'h00, "R8");
    do_write(12'h003, 8'h77, "R8");
    do_write(12'h204, 8'h0C, "R8");
    do_read(12'h103, "R8"); do_read(12'h104, "R8"); do_read(12'h105, "R8");
    do_read(12'h102, "R8"); do_read(12'h112, "R8"); do_read(12'h106, "R8");
    @(negedge clk_i);
    @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule